// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus-master side of a processor bus where a 20-bit address and a 16-bit data path share the same pins over time. A client hands it one transfer at a time: the address, read or write, memory or I/O space, a word-or-byte flag, write data and a 4-bit status nibble. The sequencer then runs a bus cycle of at least four clock states, T1 to T4. It drives the shared low lines with the address in T1 and then releases them for a read, or drives write data on them for a write. It also drives the upper lines with the address and then with status, and produces the address-latch strobe, the read and write strobes, the transceiver enable and direction, and the memory/IO select.

The addressed device holds the cycle with a READY input. Wait states are inserted after T3 until READY is seen high. A latch strobed by the sequencer's own ALE recovers the full address and the byte-high-enable from the shared lines and holds them for the rest of the cycle. A one-cycle done pulse returns the read data. Every output is registered. The shared lines are modelled as a value, an output enable and a separate input.

Top module: `mxbus_seq`

## Requirements
- R1: A cycle takes T1, T2, T3, then zero or more wait states, then T4. The done pulse is high in the clock after T4, which is 4 + W clocks after the clock in which ALE is high, where W is the number of wait states.
- R2: In T1 and only in T1, ale is 1 and ad_oe is 1. ad_o carries address bits 15:1, and ad_o[0] carries the A0 value defined in R8. as_o carries address bits 19:16. ale is never high for two clocks in a row.
- R3: From T2 through T4, as_o carries req_stat of the current transfer and bhe_n carries the status bit S7, driven 0.
- R4: In a read, from T2 until T4 begins: ad_oe=0, rd_n=0, den_n=0 and dtr=0. In T4, rd_n=1 and ad_oe stays 0.
- R5: In a write, from T2 until T4 begins: wr_n=0, den_n=0, dtr=1, ad_oe=1 and ad_o=req_wdata. In T4, wr_n=1 while ad_oe=1 and ad_o still carries the write data.
- R6: READY is sampled at the end of T3 and at the end of each wait state. While it is 0, another wait state follows. rdata is the value on ad_i at the clock edge where READY is first seen high.
- R7: mio equals req_mem (1 = memory, 0 = I/O) from T1 through T4 and does not change within a cycle.
- R8: Byte selection works as follows. req_word=1 gives A0=0 and bhe_n=0, a full word. req_word=0 with req_addr[0]=0 gives A0=0 and bhe_n=1, the low byte. req_word=0 with req_addr[0]=1 gives A0=1 and bhe_n=0, the high byte. bhe_n=1 together with A0=1 never occurs in T1.
- R9: lat_addr and lat_bhe_n take the T1 values of {as_o, ad_o} and bhe_n, and hold them unchanged from T2 until the next T1.
- R10: req_ready is 1 only when the sequencer is idle. A request presented while a cycle runs is ignored and starts no further cycle.
- R11: In the clock with done high, rd_n, wr_n and den_n are all 1 and ad_oe is 0. At least one such idle clock separates T4 from the next T1.
- R12: After reset: ale=0, ad_oe=0, rd_n=wr_n=den_n=1, done=0 and req_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte chosen by req_addr[0] |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data, lane aligned |
| req_stat | input | 4 | Status nibble shown on upper lines after T1 |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rdata | output | 16 | Read data, valid with done |
| ready | input | 1 | Device ready |
| ad_o | output | 16 | Shared address/data lines, driven value |
| ad_oe | output | 1 | Shared address/data lines output enable |
| ad_i | input | 16 | Shared address/data lines, received value |
| as_o | output | 4 | Upper address / status lines |
| bhe_n | output | 1 | Byte-high-enable / S7 line, active low |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| dtr | output | 1 | Transceiver direction, 1 = transmit |
| mio | output | 1 | 1 = memory cycle, 0 = I/O cycle |
| lat_addr | output | 20 | Demultiplexed latched address |
| lat_bhe_n | output | 1 | Latched byte-high-enable |

## Verification
The hardest situation to reach is a request that arrives while a cycle is held in a long run of wait states. Such a request must be dropped, and the held cycle must still finish with the correct data and a latched address that has not moved. The stimulus holds READY low for a chosen number of wait states from a device model that counts strobe clocks. It raises req_valid for a different address in the middle of that cycle and then watches several idle clocks for a stray ALE. Byte-lane encodings and the read/write turnaround are swept across memory and I/O cycles with zero to three wait states, and each cycle is checked phase by phase against the recorded request.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bus_state_t;

  localparam int LANE_W = 8;
endpackage

// File: rtl/mxbus_fsm.sv
module mxbus_fsm
  import mxbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic       ready,
  output bus_state_t state_q,
  output bus_state_t state_d,
  output logic       sample,
  output logic       done_q
);
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (go) state_d = ST_T1;
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3:   state_d = ready ? ST_T4 : ST_TW;
      ST_TW:   state_d = ready ? ST_T4 : ST_TW;
      ST_T4:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign sample = ((state_q == ST_T3) || (state_q == ST_TW)) && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_T4);
    end
  end
endmodule

// File: rtl/mxbus_drive.sv
module mxbus_drive
  import mxbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  bus_state_t        state_d,
  input  logic              req_rd,
  input  logic              req_mem,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [HI_W-1:0]   req_stat,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  output logic [HI_W-1:0]   as_o,
  output logic              bhe_n,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              den_n,
  output logic              dtr,
  output logic              mio
);
  logic              h_rd, h_mem, h_word;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_wdata;
  logic [HI_W-1:0]   h_stat;

  logic              s_rd, s_mem, s_word;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_wdata;
  logic [HI_W-1:0]   s_stat;
  logic              s_a0, s_bhe_n;

  // fields of the running transfer, taken straight from the request on accept
  assign s_rd    = accept ? req_rd    : h_rd;
  assign s_mem   = accept ? req_mem   : h_mem;
  assign s_word  = accept ? req_word  : h_word;
  assign s_addr  = accept ? req_addr  : h_addr;
  assign s_wdata = accept ? req_wdata : h_wdata;
  assign s_stat  = accept ? req_stat  : h_stat;

  // byte selection: word forces A0 low, odd byte raises A0 and enables the high lane
  assign s_a0    = s_addr[0] & ~s_word;
  assign s_bhe_n = ~(s_word | s_addr[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_rd    <= 1'b1;
      h_mem   <= 1'b1;
      h_word  <= 1'b1;
      h_addr  <= '0;
      h_wdata <= '0;
      h_stat  <= '0;
    end else if (accept) begin
      h_rd    <= req_rd;
      h_mem   <= req_mem;
      h_word  <= req_word;
      h_addr  <= req_addr;
      h_wdata <= req_wdata;
      h_stat  <= req_stat;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_o  <= '0;
      ad_oe <= 1'b0;
      as_o  <= '0;
      bhe_n <= 1'b1;
      ale   <= 1'b0;
      rd_n  <= 1'b1;
      wr_n  <= 1'b1;
      den_n <= 1'b1;
      dtr   <= 1'b1;
      mio   <= 1'b1;
    end else begin
      case (state_d)
        ST_T1: begin
          ad_o  <= {s_addr[DATA_W-1:1], s_a0};
          ad_oe <= 1'b1;
          as_o  <= s_addr[ADDR_W-1:DATA_W];
          bhe_n <= s_bhe_n;
          ale   <= 1'b1;
          rd_n  <= 1'b1;
          wr_n  <= 1'b1;
          den_n <= 1'b1;
          dtr   <= ~s_rd;
          mio   <= s_mem;
        end
        ST_T2, ST_T3, ST_TW: begin
          ad_o  <= s_rd ? '0 : s_wdata;
          ad_oe <= ~s_rd;
          as_o  <= s_stat;
          bhe_n <= 1'b0;
          ale   <= 1'b0;
          rd_n  <= ~s_rd;
          wr_n  <= s_rd;
          den_n <= 1'b0;
          dtr   <= ~s_rd;
          mio   <= s_mem;
        end
        ST_T4: begin
          ad_o  <= s_rd ? '0 : s_wdata;
          ad_oe <= ~s_rd;
          as_o  <= s_stat;
          bhe_n <= 1'b0;
          ale   <= 1'b0;
          rd_n  <= 1'b1;
          wr_n  <= 1'b1;
          den_n <= 1'b0;
          dtr   <= ~s_rd;
          mio   <= s_mem;
        end
        default: begin
          ad_o  <= '0;
          ad_oe <= 1'b0;
          as_o  <= '0;
          bhe_n <= 1'b1;
          ale   <= 1'b0;
          rd_n  <= 1'b1;
          wr_n  <= 1'b1;
          den_n <= 1'b1;
          dtr   <= 1'b1;
          mio   <= mio;
        end
      endcase
    end
  end
endmodule

// File: rtl/mxbus_alatch.sv
module mxbus_alatch
  import mxbus_pkg::*;
#(
  parameter int WIDTH = 21,
  localparam int NSL  = (WIDTH + LANE_W - 1) / LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < NSL; g++) begin : g_slice
    localparam int LO = g * LANE_W;
    localparam int HI = (LO + LANE_W > WIDTH) ? WIDTH - 1 : LO + LANE_W - 1;
    logic [HI-LO:0] slice_q;
    always_ff @(posedge clk) begin
      if (rst)      slice_q <= '0;
      else if (stb) slice_q <= din[HI:LO];
    end
    assign q[HI:LO] = slice_q;
  end
endmodule

// File: rtl/mxbus_seq.sv
module mxbus_seq
  import mxbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_rd,
  input  logic              req_mem,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [HI_W-1:0]   req_stat,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  input  logic              ready,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_i,
  output logic [HI_W-1:0]   as_o,
  output logic              bhe_n,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              den_n,
  output logic              dtr,
  output logic              mio,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              lat_bhe_n
);
  bus_state_t        state_q, state_d;
  logic              accept, sample;
  logic [DATA_W-1:0] rdata_q;
  logic [ADDR_W:0]   lat_q;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  mxbus_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .go      (accept),
    .ready   (ready),
    .state_q (state_q),
    .state_d (state_d),
    .sample  (sample),
    .done_q  (done)
  );

  mxbus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .state_d   (state_d),
    .req_rd    (req_rd),
    .req_mem   (req_mem),
    .req_word  (req_word),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_stat  (req_stat),
    .ad_o      (ad_o),
    .ad_oe     (ad_oe),
    .as_o      (as_o),
    .bhe_n     (bhe_n),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .den_n     (den_n),
    .dtr       (dtr),
    .mio       (mio)
  );

  mxbus_alatch #(.WIDTH(ADDR_W + 1)) u_latch (
    .clk (clk),
    .rst (rst),
    .stb (ale),
    .din ({bhe_n, as_o, ad_o}),
    .q   (lat_q)
  );

  assign lat_addr  = lat_q[ADDR_W-1:0];
  assign lat_bhe_n = lat_q[ADDR_W];

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (sample) rdata_q <= ad_i;
  end
  assign rdata = rdata_q;
endmodule

// File: rtl/mxbus_seq_chk.sv
module mxbus_seq_chk (
  input logic clk,
  input logic rst,
  input logic ale,
  input logic ad_oe,
  input logic ad_o0,
  input logic rd_n,
  input logic wr_n,
  input logic den_n,
  input logic dtr,
  input logic mio,
  input logic bhe_n,
  input logic done,
  input logic req_ready
);
  assert_ale_drives_R2: assert property (@(posedge clk) disable iff (rst)
    ale |-> ad_oe && rd_n && wr_n);

  assert_ale_single_R2: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  assert_read_turn_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe && !den_n && !dtr);

  assert_write_drive_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> ad_oe && dtr && !den_n);

  assert_write_after_t1_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n) |-> $past(ale));

  assert_mio_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !den_n |-> $stable(mio));

  assert_byte_code_R8: assert property (@(posedge clk) disable iff (rst)
    ale |-> !(bhe_n && ad_o0));

  assert_idle_end_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> rd_n && wr_n && den_n && !ad_oe);

  assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
    !den_n |-> !req_ready);
endmodule

bind mxbus_seq mxbus_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ale       (ale),
  .ad_oe     (ad_oe),
  .ad_o0     (ad_o[0]),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .den_n     (den_n),
  .dtr       (dtr),
  .mio       (mio),
  .bhe_n     (bhe_n),
  .done      (done),
  .req_ready (req_ready)
);

// File: tb/mxbus_seq_tb.sv
`timescale 1ns/1ps
module mxbus_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_rd = 1'b1, req_mem = 1'b1, req_word = 1'b1;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [3:0]  req_stat = '0;
  logic        ready = 1'b0;
  logic [15:0] ad_i = '0;
  logic        req_ready, done, ad_oe, bhe_n, ale, rd_n, wr_n, den_n, dtr, mio, lat_bhe_n;
  logic [15:0] rdata, ad_o;
  logic [3:0]  as_o;
  logic [19:0] lat_addr;

  always #4 clk = ~clk;

  mxbus_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_rd(req_rd), .req_mem(req_mem), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_stat(req_stat), .done(done), .rdata(rdata),
    .ready(ready), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .as_o(as_o),
    .bhe_n(bhe_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n),
    .dtr(dtr), .mio(mio), .lat_addr(lat_addr), .lat_bhe_n(lat_bhe_n)
  );

  typedef struct {
    logic        rd, mem, word;
    logic [19:0] addr;
    logic [15:0] wdata, rdata;
    logic [3:0]  stat;
    int          waits;
  } item_t;

  item_t       exp_q[$];
  item_t       cur;
  int          checks = 0, failures = 0;
  int          ph = 0;
  int          strobe_cnt = 0;
  logic [15:0] dev_data = '0;
  int          dev_waits = 0;
  logic        busy_watch = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [19:0] exp_addr(input item_t it);
    return {it.addr[19:1], it.addr[0] & ~it.word};
  endfunction

  function automatic logic exp_bhe(input item_t it);
    return ~(it.word | it.addr[0]);
  endfunction

  // device model: READY rises after the requested number of wait states
  always @(negedge clk) begin
    if (!rd_n || !wr_n) strobe_cnt = strobe_cnt + 1;
    else                strobe_cnt = 0;
    ready = (strobe_cnt >= 2 + dev_waits);
    ad_i  = rd_n ? 16'h0000 : dev_data;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (ale) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected cycle start", 32'(lat_addr), 32'h0);
        end else begin
          cur = exp_q[0];
          ph = 1;
          chk({as_o, ad_o} == exp_addr(cur) && ad_oe, "R2 T1 address",
              32'({as_o, ad_o}), 32'(exp_addr(cur)));
          chk(bhe_n == exp_bhe(cur), "R8 byte select", 32'(bhe_n), 32'(exp_bhe(cur)));
          chk(mio == cur.mem, "R7 mio in T1", 32'(mio), 32'(cur.mem));
        end
      end else if (ph > 0) begin
        ph = ph + 1;
        if (ph == 2) begin
          chk(as_o == cur.stat && bhe_n == 1'b0, "R3 status lines",
              32'({bhe_n, as_o}), 32'({1'b0, cur.stat}));
          if (cur.rd)
            chk(!ad_oe && !rd_n && !den_n && !dtr && wr_n, "R4 read T2",
                32'({ad_oe, rd_n, den_n, dtr}), 32'h0);
          else
            chk(ad_oe && ad_o == cur.wdata && !wr_n && !den_n && dtr && rd_n, "R5 write T2",
                32'({ad_oe, wr_n, den_n, dtr, ad_o}), 32'({4'b1001, cur.wdata}));
        end
        if (!done)
          chk(lat_addr == exp_addr(cur) && lat_bhe_n == exp_bhe(cur), "R9 latch hold",
              32'({lat_bhe_n, lat_addr}), 32'({exp_bhe(cur), exp_addr(cur)}));
        if (!done && ph > 1)
          chk(mio == cur.mem, "R7 mio held", 32'(mio), 32'(cur.mem));
        if (ph == 4 + cur.waits) begin
          if (cur.rd)
            chk(rd_n && !ad_oe, "R4 read T4", 32'({rd_n, ad_oe}), 32'h2);
          else
            chk(wr_n && ad_oe && ad_o == cur.wdata, "R5 write T4",
                32'({wr_n, ad_oe, ad_o}), 32'({2'b11, cur.wdata}));
        end
        if (done) begin
          chk(ph == 5 + cur.waits, "R1 cycle length", 32'(ph), 32'(5 + cur.waits));
          chk(rd_n && wr_n && den_n && !ad_oe, "R11 end of cycle",
              32'({rd_n, wr_n, den_n, ad_oe}), 32'he);
          if (cur.rd)
            chk(rdata == cur.rdata, "R6 read data", 32'(rdata), 32'(cur.rdata));
          void'(exp_q.pop_front());
          ph = 0;
        end
      end
    end
  end

  task automatic do_xfer(input logic rd, input logic mem, input logic word,
                         input logic [19:0] addr, input logic [15:0] wd,
                         input logic [3:0] st, input logic [15:0] dd, input int w);
    item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    it.rd = rd; it.mem = mem; it.word = word; it.addr = addr;
    it.wdata = wd; it.rdata = dd; it.stat = st; it.waits = w;
    dev_data = dd; dev_waits = w;
    req_rd = rd; req_mem = mem; req_word = word; req_addr = addr;
    req_wdata = wd; req_stat = st; req_valid = 1'b1;
    exp_q.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(!ale && !ad_oe && rd_n && wr_n && den_n && !done && req_ready, "R12 reset state",
        32'({ale, ad_oe, rd_n, wr_n, den_n, done, req_ready}), 32'b0011101);

    do_xfer(1'b1, 1'b1, 1'b1, 20'hA5C3E, 16'h0000, 4'h3, 16'h1234, 0); // word read, mem
    do_xfer(1'b0, 1'b0, 1'b1, 20'h0F0F2, 16'hBEEF, 4'h5, 16'h0000, 0); // word write, io
    do_xfer(1'b1, 1'b1, 1'b0, 20'h12340, 16'h0000, 4'h9, 16'h00C7, 3); // low byte read
    do_xfer(1'b0, 1'b1, 1'b0, 20'hFFFFF, 16'h5A00, 4'hA, 16'h0000, 1); // high byte write
    do_xfer(1'b1, 1'b0, 1'b0, 20'h80001, 16'h0000, 4'h6, 16'h9900, 2); // high byte read, io
    do_xfer(1'b0, 1'b0, 1'b0, 20'h00010, 16'h0042, 4'hF, 16'h0000, 0); // low byte write, io
    do_xfer(1'b1, 1'b1, 1'b1, 20'h00000, 16'h0000, 4'h0, 16'hFFFF, 1); // back to back read

    // R10: request raised mid-cycle must be ignored
    fork
      do_xfer(1'b1, 1'b1, 1'b1, 20'h2468A, 16'h0000, 4'h1, 16'hCAFE, 3);
      begin
        repeat (4) @(negedge clk);
        chk(!req_ready, "R10 busy flag", 32'(req_ready), 32'h0);
        req_addr = 20'h13579; req_rd = 1'b0; req_valid = 1'b1;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
      end
    join
    repeat (5) @(negedge clk) begin
      chk(!ale && req_ready, "R10 no stray cycle", 32'({ale, req_ready}), 32'h1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule